// File: doc/BRIEF.md
# Voice Scrambler Command Receiver

This block is a receive-only two-wire serial (I2C) slave that takes commands for a voice scrambler and keeps its operating mode. A fast system clock samples the bus clock and data lines, passes each through a synchronizer and a glitch filter, and detects START and STOP conditions. It also collects bits into bytes and pulls the data line low to acknowledge.

The first byte after a START carries a 7-bit address and a direction bit. The top six address bits are a parameter and the lowest bit comes from a strap pin. Only writes to the matching address are acknowledged. Every following data byte is acknowledged, and the low nibble of each is decoded into one of three modes: mute, transparent or scramble. The nibble can also select one of nine split-frequency indices.

The chip-level controller reads the mode flags and the index to steer the analog signal path. A transfer may carry any number of command bytes, and each byte takes effect on its own. Outputs change one system cycle after the falling edge of the acknowledge clock.

Top module: `vsc_cmd_rx`

## Requirements
- R1: After reset, mute_o=1, transparent_o=0, scramble_o=0, split_idx_o=0 and sda_oe_o=0 (SDA released).
- R2: An address byte equal to {ADDR_HI, addr_lsb_i, 0} (MSB first, last bit the write direction 0) is acknowledged. The slave holds SDA low for the whole high phase of the ninth clock.
- R3: An address byte with the wrong lowest address bit, or with the direction bit 1, is not acknowledged. All bytes up to the next START are then ignored: no acknowledge and no change of the outputs.
- R4: Every data byte after an acknowledged address is itself acknowledged and applied, however many follow in one transfer.
- R5: Data byte 0x01 selects mute: mute_o=1, the other flags 0, index unchanged.
- R6: Data bytes 0x02 to 0x0A set split_idx_o to the code minus 2 (0 to 8) and select scramble (scramble_o=1).
- R7: Data byte 0x0B selects transparent: transparent_o=1, the other flags 0, index unchanged.
- R8: Data byte 0x0F selects scramble and keeps the most recent index.
- R9: Any other data byte (0x00, 0x0C to 0x0E, or any byte whose upper four bits are not zero) is acknowledged but leaves every output unchanged.
- R10: A pulse on SCL or SDA shorter than the filter width (100 ns at the default clock) has no effect on the received bits or on START/STOP detection.
- R11: A STOP in the middle of a byte discards the partial byte. A repeated START restarts address reception.
- R12: The acknowledge drive on SDA is asserted only while SCL is low, and it is released by STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, clears all state |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_lsb_i | input | 1 | Strap that sets the lowest address bit |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge), 0 releases it |
| mute_o | output | 1 | Mute mode active |
| transparent_o | output | 1 | Transparent mode active |
| scramble_o | output | 1 | Scramble/descramble mode active |
| split_idx_o | output | 4 | Selected split-frequency index, 0 to 8 |

## Verification
The bench sends a 0x0F after mute and after transparent. A design that reloaded or cleared the index on that code would show the wrong split_idx_o. Bytes with a nonzero upper nibble and the unlisted nibbles must be acknowledged yet change nothing; a decoder that looked only at the low nibble, or that refused to acknowledge, fails the output or the acknowledge check. The address is also sent with the wrong strap bit and with the read bit set; a slave that stayed attached would acknowledge, or would apply the command that follows. Short pulses on both lines during a byte, a STOP after seven bits and a repeated START catch a filter that is too narrow, a bit counter that is not cleared, and a partial byte that gets applied anyway.

// File: rtl/vsc_cmd_pkg.sv
package vsc_cmd_pkg;

    localparam int unsigned SPLIT_COUNT = 9;

    typedef enum logic [1:0] {
        MD_MUTE     = 2'd0,
        MD_CLEAR    = 2'd1,
        MD_SCRAMBLE = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        BS_IDLE  = 3'd0,
        BS_ADDR  = 3'd1,
        BS_ACK_A = 3'd2,
        BS_DATA  = 3'd3,
        BS_ACK_D = 3'd4,
        BS_SKIP  = 3'd5
    } bus_st_e;

    typedef struct packed {
        logic       valid;
        mode_e      mode;
        logic       keep_idx;
        logic [3:0] idx;
    } cmd_t;

    // Maps one received data byte to a mode change; invalid bytes give valid=0.
    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t r;
        r.valid    = 1'b0;
        r.mode     = MD_MUTE;
        r.keep_idx = 1'b1;
        r.idx      = 4'd0;
        if (b[7:4] == 4'd0) begin
            case (b[3:0])
                4'h1: begin r.valid = 1'b1; r.mode = MD_MUTE;     end
                4'hB: begin r.valid = 1'b1; r.mode = MD_CLEAR;    end
                4'hF: begin r.valid = 1'b1; r.mode = MD_SCRAMBLE; end
                default: begin
                    if (b[3:0] >= 4'd2 && b[3:0] <= 4'(SPLIT_COUNT + 1)) begin
                        r.valid    = 1'b1;
                        r.mode     = MD_SCRAMBLE;
                        r.keep_idx = 1'b0;
                        r.idx      = b[3:0] - 4'd2;
                    end
                end
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/vsc_line_filter.sv
module vsc_line_filter #(
    parameter int unsigned FILT_CYC = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], line_i};
        if (q.sync[1] != q.filt) begin
            if (q.cnt == CW'(FILT_CYC - 1)) begin
                d.filt = q.sync[1];
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= 2'b11;
            q.filt <= 1'b1;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.filt;

    // R10: the filtered level moves only after the synchronized input has differed for the full window
    p_filter_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.filt) |-> ($past(q.sync[1]) == q.filt) && ($past(q.cnt) == CW'(FILT_CYC - 1)));

endmodule

// File: rtl/vsc_byte_rx.sv
module vsc_byte_rx
    import vsc_cmd_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b011010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic       addr_lsb,
    output logic       sda_oe,
    output logic       byte_stb,
    output logic [7:0] byte_o
);
    typedef struct packed {
        bus_st_e    st;
        logic       scl_p;
        logic       sda_p;
        logic [3:0] bitcnt;
        logic [7:0] sr;
        logic       ack;
        logic       stb;
    } rx_t;

    rx_t  q, d;
    logic scl_rise, scl_fall, start_c, stop_c;

    always_comb begin
        scl_rise = scl_f & ~q.scl_p;
        scl_fall = ~scl_f & q.scl_p;
        start_c  = scl_f & q.scl_p & q.sda_p & ~sda_f;
        stop_c   = scl_f & q.scl_p & ~q.sda_p & sda_f;

        d       = q;
        d.scl_p = scl_f;
        d.sda_p = sda_f;
        d.stb   = 1'b0;

        if (start_c) begin
            d.st     = BS_ADDR;
            d.bitcnt = 4'd0;
            d.ack    = 1'b0;
        end else if (stop_c) begin
            d.st     = BS_IDLE;
            d.bitcnt = 4'd0;
            d.ack    = 1'b0;
        end else begin
            case (q.st)
                BS_ADDR, BS_DATA: begin
                    if (scl_rise && q.bitcnt < 4'd8) begin
                        d.sr     = {q.sr[6:0], sda_f};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        d.bitcnt = 4'd0;
                        if (q.st == BS_DATA) begin
                            d.ack = 1'b1;
                            d.st  = BS_ACK_D;
                        end else if (q.sr == {ADDR_HI, addr_lsb, 1'b0}) begin
                            d.ack = 1'b1;
                            d.st  = BS_ACK_A;
                        end else begin
                            d.st  = BS_SKIP;
                        end
                    end
                end
                BS_ACK_A: begin
                    if (scl_fall) begin
                        d.ack = 1'b0;
                        d.st  = BS_DATA;
                    end
                end
                BS_ACK_D: begin
                    if (scl_fall) begin
                        d.ack = 1'b0;
                        d.stb = 1'b1;
                        d.st  = BS_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= BS_IDLE;
            q.scl_p  <= 1'b1;
            q.sda_p  <= 1'b1;
            q.bitcnt <= 4'd0;
            q.sr     <= 8'd0;
            q.ack    <= 1'b0;
            q.stb    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe   = q.ack;
    assign byte_stb = q.stb;
    assign byte_o   = q.sr;

    // R12: acknowledge drive starts only while the bus clock is low
    p_ack_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ack) |-> !scl_f);

    // R12: a STOP releases the line and returns to idle
    p_stop_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (!q.ack && q.st == BS_IDLE));

    // R4: a command strobe follows only a data acknowledge
    p_strobe_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.stb |-> ($past(q.st) == BS_ACK_D));

    // R3: no acknowledge while detached from the bus
    p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == BS_SKIP) |-> !q.ack);

endmodule

// File: rtl/vsc_mode_reg.sv
module vsc_mode_reg
    import vsc_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_stb,
    input  logic [7:0] cmd_byte,
    output logic       mute,
    output logic       transparent,
    output logic       scramble,
    output logic [3:0] split_idx
);
    typedef struct packed {
        mode_e      mode;
        logic [3:0] idx;
    } md_t;

    md_t  q, d;
    cmd_t cmd;

    always_comb begin
        cmd = decode_cmd(cmd_byte);
        d   = q;
        if (cmd_stb && cmd.valid) begin
            d.mode = cmd.mode;
            if (!cmd.keep_idx) d.idx = cmd.idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode <= MD_MUTE;
            q.idx  <= 4'd0;
        end else begin
            q <= d;
        end
    end

    assign mute        = (q.mode == MD_MUTE);
    assign transparent = (q.mode == MD_CLEAR);
    assign scramble    = (q.mode == MD_SCRAMBLE);
    assign split_idx   = q.idx;

    // R9: unlisted or nonzero-upper-nibble bytes leave everything as it was
    p_bad_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && !(cmd_byte inside {[8'h01:8'h0B], 8'h0F})) |=> $stable(q));

    // R6: split codes load code minus two and enter scramble
    p_split_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_byte inside {[8'h02:8'h0A]}) |=>
        (q.idx == $past(cmd_byte[3:0]) - 4'd2) && (q.mode == MD_SCRAMBLE));

    // R8: the start code keeps the last index
    p_start_keeps_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_byte == 8'h0F) |=> ($stable(q.idx) && q.mode == MD_SCRAMBLE));

    // R5 R7: mute and transparent never touch the index
    p_mode_keeps_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && (cmd_byte == 8'h01 || cmd_byte == 8'h0B)) |=> $stable(q.idx));

endmodule

// File: rtl/vsc_cmd_rx.sv
module vsc_cmd_rx #(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned GLITCH_NS = 100,
    parameter logic [5:0]  ADDR_HI   = 6'b011010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       addr_lsb_i,
    output logic       sda_oe_o,
    output logic       mute_o,
    output logic       transparent_o,
    output logic       scramble_o,
    output logic [3:0] split_idx_o
);
    localparam int unsigned CLK_MHZ  = CLK_HZ / 1_000_000;
    localparam int unsigned FILT_CYC = (CLK_MHZ * GLITCH_NS) / 1000 + 1;
    localparam int unsigned N_LINES  = 2;

    logic [N_LINES-1:0] raw_lines, filt_lines;
    logic               byte_stb;
    logic [7:0]         byte_val;

    assign raw_lines = {scl_i, sda_i};

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_filt
        vsc_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[gi]),
            .line_o (filt_lines[gi])
        );
    end

    vsc_byte_rx #(.ADDR_HI(ADDR_HI)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (filt_lines[1]),
        .sda_f    (filt_lines[0]),
        .addr_lsb (addr_lsb_i),
        .sda_oe   (sda_oe_o),
        .byte_stb (byte_stb),
        .byte_o   (byte_val)
    );

    vsc_mode_reg u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_stb     (byte_stb),
        .cmd_byte    (byte_val),
        .mute        (mute_o),
        .transparent (transparent_o),
        .scramble    (scramble_o),
        .split_idx   (split_idx_o)
    );

    // R5 R7 R8: exactly one mode flag at any time after reset
    p_one_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mute_o, transparent_o, scramble_o}) == 1);

    // R6: the index never leaves the nine defined values
    p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        split_idx_o <= 4'd8);

endmodule

// File: tb/vsc_cmd_rx_test.sv
module vsc_cmd_rx_test;
    localparam int Q = 40;
    localparam logic [5:0] AHI = 6'b011010;
    localparam int NV = 13;
    // {command byte, mute, transparent, scramble, index}
    localparam logic [14:0] VEC [NV] = '{
        {8'h02, 3'b001, 4'd0},
        {8'h0A, 3'b001, 4'd8},
        {8'h01, 3'b100, 4'd8},
        {8'h0F, 3'b001, 4'd8},
        {8'h0B, 3'b010, 4'd8},
        {8'h05, 3'b001, 4'd3},
        {8'h0C, 3'b001, 4'd3},
        {8'h15, 3'b001, 4'd3},
        {8'h00, 3'b001, 4'd3},
        {8'h01, 3'b100, 4'd3},
        {8'h0E, 3'b100, 4'd3},
        {8'h0F, 3'b001, 4'd3},
        {8'h03, 3'b001, 4'd1}
    };

    logic clk = 0, rst_n = 0, scl = 1, sda_m = 1, a_sel = 1;
    logic sda_oe, mute, transp, scram, sda_line;
    logic [3:0] idx;
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    vsc_cmd_rx uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .addr_lsb_i(a_sel),
        .sda_oe_o(sda_oe), .mute_o(mute), .transparent_o(transp),
        .scramble_o(scram), .split_idx_o(idx)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic i_start();
        sda_m = 1; wq(Q); scl = 1; wq(Q); sda_m = 0; wq(Q); scl = 0; wq(Q);
    endtask

    task automatic i_stop();
        sda_m = 0; wq(Q); scl = 1; wq(Q); sda_m = 1; wq(Q);
    endtask

    task automatic send_bit(input logic b, input bit gl);
        sda_m = b;
        wq(Q / 2);
        if (gl) begin scl = 1; wq(4); scl = 0; end
        wq(Q / 2);
        scl = 1; wq(Q);
        if (gl && b) begin sda_m = 0; wq(4); sda_m = 1; end
        wq(Q);
        scl = 0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req, input bit gl);
        for (int i = 7; i >= 0; i--) send_bit(b[i], gl);
        sda_m = 1; wq(Q); scl = 1; wq(Q);
        chk(req, {31'd0, ~sda_line}, {31'd0, exp_ack});
        wq(Q); scl = 0; wq(Q);
    endtask

    function automatic logic [7:0] adr(input logic lsb, input logic rw);
        return {AHI, lsb, rw};
    endfunction

    task automatic chk_state(input string req, input logic [6:0] exp);
        wq(20);
        chk(req, {25'd0, mute, transp, scram, idx}, {25'd0, exp});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wq(5); rst_n = 1; wq(5);
        // R1: reset state
        chk("R1 outputs", {24'd0, sda_oe, mute, transp, scram, idx}, {24'd0, 8'b0_100_0000});

        // Vector table: one write per entry (R2 R4 R5 R6 R7 R8 R9 R12)
        for (int v = 0; v < NV; v++) begin
            i_start();
            send_byte(adr(1'b1, 1'b0), 1'b1, "R2 R12 address ack", 1'b0);
            send_byte(VEC[v][14:7], 1'b1, "R4 R9 data ack", 1'b0);
            i_stop();
            chk_state("R5 R6 R7 R8 R9 vector state", VEC[v][6:0]);
        end

        // R4: several data bytes in one transfer
        i_start();
        send_byte(adr(1'b1, 1'b0), 1'b1, "R4 address ack", 1'b0);
        send_byte(8'h09, 1'b1, "R4 byte1 ack", 1'b0);
        send_byte(8'h0B, 1'b1, "R4 byte2 ack", 1'b0);
        send_byte(8'h04, 1'b1, "R4 byte3 ack", 1'b0);
        i_stop();
        chk_state("R4 multi-byte final", 7'b001_0010);

        // R3: wrong strap bit, then a read request
        i_start();
        send_byte(adr(1'b0, 1'b0), 1'b0, "R3 mismatch nack", 1'b0);
        send_byte(8'h01, 1'b0, "R3 ignored data nack", 1'b0);
        i_stop();
        chk_state("R3 state unchanged", 7'b001_0010);
        i_start();
        send_byte(adr(1'b1, 1'b1), 1'b0, "R3 read nack", 1'b0);
        send_byte(8'h0B, 1'b0, "R3 ignored after read", 1'b0);
        i_stop();
        chk_state("R3 state after read", 7'b001_0010);

        // R2: strap low moves the address
        a_sel = 0;
        i_start();
        send_byte(adr(1'b0, 1'b0), 1'b1, "R2 strap0 ack", 1'b0);
        send_byte(8'h01, 1'b1, "R2 strap0 data ack", 1'b0);
        i_stop();
        chk_state("R2 strap0 mute", 7'b100_0010);

        // R10: short pulses on SCL and SDA inside every bit
        i_start();
        send_byte(adr(1'b0, 1'b0), 1'b1, "R10 address ack", 1'b1);
        send_byte(8'h0B, 1'b1, "R10 data ack", 1'b1);
        i_stop();
        chk_state("R10 glitches ignored", 7'b010_0010);

        // R11: STOP after seven bits of 0x0F
        i_start();
        send_byte(adr(1'b0, 1'b0), 1'b1, "R11 address ack", 1'b0);
        for (int i = 7; i >= 1; i--) send_bit(1'(8'h0F >> i), 1'b0);
        i_stop();
        chk_state("R11 partial byte dropped", 7'b010_0010);
        chk("R11 line released", {31'd0, sda_oe}, 32'd0);

        // R11: repeated START restarts address reception
        i_start();
        send_byte(adr(1'b0, 1'b0), 1'b1, "R11 first address ack", 1'b0);
        i_start();
        send_byte(adr(1'b0, 1'b0), 1'b1, "R11 repeated address ack", 1'b0);
        send_byte(8'h0F, 1'b1, "R11 data ack", 1'b0);
        i_stop();
        chk_state("R11 R8 after repeated start", 7'b001_0010);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule